// File: doc/BRIEF.md
# Nonce Search Configuration Register File

This block is the register file that sits between a 32-bit Wishbone bus and a hash-based nonce search engine. Software writes the 256-bit block header, the 256-bit target threshold, the 64-bit starting nonce and a control word. The block presents these values continuously to the search logic. In the other direction it reports the solution nonce, a status word built from the engine's flags, and a constant identification word.

The register file raises an interrupt when the engine reports a new solution. The interrupt stays raised until software reads the control word. Multi-word values are spread over consecutive word addresses, least significant word first. Every writable word honours the byte-lane selects. A single clock drives both the bus side and the exported configuration, and reset is asynchronous.

Top module: `miner_cfg_regs`

## Requirements
- R1: While reset is asserted and right after it, acknowledge and interrupt are low. Header, threshold and start nonce read as zero. The control word reads 0x0680_0000, so the first pad byte is 0x06, the last pad byte is 0x80, and the run, test and halt bits are 0.
- R2: A request is accepted when cycle and strobe are both high and acknowledge is low. Acknowledge is high in the following cycle only, and no acknowledge appears without cycle. Read data is zero whenever acknowledge is low.
- R3: The word index is address bits [6:2]. Words 4 to 11 hold the header, and word 4 carries header bits [31:0]. The header output follows the stored words from the cycle after an accepted write.
- R4: Words 12 to 19 hold the threshold, with word 12 carrying bits [31:0]. Words 20 and 21 hold the start nonce, with word 20 carrying bits [31:0].
- R5: Word 22 is the control word: bit 0 run, bit 1 test, bit 2 halt, bits [23:16] last pad byte, bits [31:24] first pad byte. Each field drives its own output.
- R6: On a write, select bit k enables the update of data bits [8k+7:8k] of the addressed writable word. An all-zero select changes nothing.
- R7: Word 0 reads solution bits [31:0] and word 1 reads solution bits [63:32], both taken from the engine's solution input.
- R8: Word 2 reads status: bit 0 solution found, bit 1 running, bit 2 testing, and all other bits 0.
- R9: Word 3 reads the constant 0x5348_4133, which is the ASCII text "SHA3" with "S" in bits [31:24].
- R10: Writes to words 0 to 3 and 23 to 31 are acknowledged but change no stored word and no configuration output.
- R11: Reads of words 23 to 31 return zero.
- R12: The interrupt sets on a low-to-high change of the found input. It holds until a read of word 22 is accepted, which clears it. Reads of other words and writes of word 22 leave it set. A rising found input in the same cycle as the clearing read keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and configuration |
| arst | input | 1 | Asynchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_sel | input | 4 | Byte-lane selects |
| bus_adr | input | 32 | Byte address |
| bus_wdat | input | 32 | Write data |
| bus_ack | output | 1 | Single-cycle acknowledge |
| bus_rdat | output | 32 | Read data, valid with acknowledge |
| core_found | input | 1 | Engine has a solution |
| core_running | input | 1 | Engine is searching |
| core_testing | input | 1 | Engine is in exact-match test mode |
| core_soln | input | 64 | Solution nonce |
| cfg_header | output | 256 | Stored header |
| cfg_diff | output | 256 | Stored threshold |
| cfg_start | output | 64 | Stored start nonce |
| cfg_run | output | 1 | Run control bit |
| cfg_test | output | 1 | Test control bit |
| cfg_halt | output | 1 | Halt control bit |
| cfg_pad_last | output | 8 | Last pad byte |
| cfg_pad_first | output | 8 | First pad byte |
| irq | output | 1 | Solution interrupt |

## Verification
The hardest situation to reach is the interrupt life cycle. In this sequence the found flag stays high while non-clearing accesses happen, then falls, and then rises again after a clearing read. The stimulus holds the found input high across a status read and a control write, confirms the interrupt survives both, clears it with a control read, and shows that a found flag that stays high does not re-arm it. It then drops and re-raises the flag to show a second edge sets it again. Byte-lane masking and read-only aliases are reached by partial-select writes and full-ones writes to every non-writable index, followed by read-back of every writable word.

// File: rtl/miner_cfg_pkg.sv
package miner_cfg_pkg;

   localparam int unsigned WORD_W = 32;

   // identification constant: ASCII "SHA3", first character in the top byte
   localparam logic [WORD_W-1:0] ID_WORD = 32'h5348_4133;

   // control word field positions (the search engine decodes these)
   localparam int unsigned CTL_RUN_BIT   = 0;
   localparam int unsigned CTL_TEST_BIT  = 1;
   localparam int unsigned CTL_HALT_BIT  = 2;
   localparam int unsigned CTL_PADL_LSB  = 16;
   localparam int unsigned CTL_PADF_LSB  = 24;

   // control word reset: first pad 0x06, last pad 0x80, all control bits clear
   localparam logic [WORD_W-1:0] CTL_RESET = 32'h0680_0000;

endpackage

// File: rtl/mcr_bus_ctrl.sv
module mcr_bus_ctrl #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned IDX_LSB = 2,
   parameter int unsigned IDX_W   = 5
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              cyc,
   input  logic              stb,
   input  logic              we,
   input  logic [ADDR_W-1:0] adr,
   output logic              ack,
   output logic              wr_acc,
   output logic              rd_acc,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

   generate
      if (IDX_MSB >= ADDR_W) begin : g_bad_idx
         $error("word index field exceeds address width");
      end
   endgenerate

   logic acc;
   logic unused_adr_bits;

   assign acc    = cyc & stb & ~ack;
   assign wr_acc = acc & we;
   assign rd_acc = acc & ~we;
   assign idx    = adr[IDX_MSB:IDX_LSB];
   assign unused_adr_bits = ^{adr[ADDR_W-1:IDX_MSB+1], adr[IDX_LSB-1:0]};

   always_ff @(posedge clk or posedge arst) begin
      if (arst) ack <= 1'b0;
      else      ack <= acc;
   end

   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (arst)
      (cyc && stb && !ack) |=> ack); // R2
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (arst)
      ack |=> !ack); // R2
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (arst)
      ack |-> $past(cyc && stb)); // R2

endmodule

// File: rtl/mcr_rw_word.sv
module mcr_rw_word #(
   parameter int unsigned       W         = 32,
   parameter logic [W-1:0]      RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             wr,
   input  logic [W/8-1:0]   sel,
   input  logic [W-1:0]     d,
   output logic [W-1:0]     q
);

   localparam int unsigned LANES = W / 8;

   generate
      if (W % 8 != 0) begin : g_bad_width
         $error("register width must be a whole number of bytes");
      end
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         always_ff @(posedge clk or posedge arst) begin
            if (arst)              q[b*8 +: 8] <= RESET_VAL[b*8 +: 8];
            else if (wr && sel[b]) q[b*8 +: 8] <= d[b*8 +: 8];
         end
      end
   endgenerate

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (arst)
      !wr |=> $stable(q)); // R10

endmodule

// File: rtl/mcr_irq.sv
module mcr_irq (
   input  logic clk,
   input  logic arst,
   input  logic found,
   input  logic clr,
   output logic irq
);

   logic found_d;
   logic rise;

   assign rise = found & ~found_d;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         found_d <= 1'b0;
         irq     <= 1'b0;
      end else begin
         found_d <= found;
         irq     <= rise | (irq & ~clr);
      end
   end

   AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (arst)
      $rose(found) |=> irq); // R12
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (arst)
      (clr && !$rose(found)) |=> !irq); // R12
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (arst)
      (irq && !clr) |=> irq); // R12

endmodule

// File: rtl/miner_cfg_regs.sv
module miner_cfg_regs
   import miner_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned HDR_W   = 256,
   parameter int unsigned DIFF_W  = 256,
   parameter int unsigned NONCE_W = 64,
   parameter int unsigned IDX_LSB = 2,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                clk,
   input  logic                arst,
   input  logic                bus_cyc,
   input  logic                bus_stb,
   input  logic                bus_we,
   input  logic [DATA_W/8-1:0] bus_sel,
   input  logic [ADDR_W-1:0]   bus_adr,
   input  logic [DATA_W-1:0]   bus_wdat,
   output logic                bus_ack,
   output logic [DATA_W-1:0]   bus_rdat,
   input  logic                core_found,
   input  logic                core_running,
   input  logic                core_testing,
   input  logic [NONCE_W-1:0]  core_soln,
   output logic [HDR_W-1:0]    cfg_header,
   output logic [DIFF_W-1:0]   cfg_diff,
   output logic [NONCE_W-1:0]  cfg_start,
   output logic                cfg_run,
   output logic                cfg_test,
   output logic                cfg_halt,
   output logic [7:0]          cfg_pad_last,
   output logic [7:0]          cfg_pad_first,
   output logic                irq
);

   // word map, derived from the widths
   localparam int unsigned SOLN_WORDS  = NONCE_W / DATA_W;
   localparam int unsigned HDR_WORDS   = HDR_W / DATA_W;
   localparam int unsigned DIFF_WORDS  = DIFF_W / DATA_W;
   localparam int unsigned START_WORDS = NONCE_W / DATA_W;
   localparam int unsigned STAT_IDX    = SOLN_WORDS;
   localparam int unsigned ID_IDX      = STAT_IDX + 1;
   localparam int unsigned RW_BASE     = ID_IDX + 1;
   localparam int unsigned RW_WORDS    = HDR_WORDS + DIFF_WORDS + START_WORDS + 1;
   localparam int unsigned NUM_WORDS   = RW_BASE + RW_WORDS;
   // positions inside the writable bank
   localparam int unsigned HDR_OFS     = 0;
   localparam int unsigned DIFF_OFS    = HDR_OFS + HDR_WORDS;
   localparam int unsigned START_OFS   = DIFF_OFS + DIFF_WORDS;
   localparam int unsigned CTL_OFS     = START_OFS + START_WORDS;
   localparam int unsigned CTL_IDX     = RW_BASE + CTL_OFS;

   generate
      if (DATA_W != WORD_W) begin : g_bad_data
         $error("bus data width must be 32");
      end
      if ((HDR_W % DATA_W) != 0 || (DIFF_W % DATA_W) != 0 || (NONCE_W % DATA_W) != 0) begin : g_bad_fields
         $error("field widths must be whole words");
      end
      if (NUM_WORDS > (1 << IDX_W)) begin : g_bad_map
         $error("word map does not fit the index field");
      end
   endgenerate

   logic             wr_acc;
   logic             rd_acc;
   logic [IDX_W-1:0] idx;

   mcr_bus_ctrl #(
      .ADDR_W (ADDR_W),
      .IDX_LSB(IDX_LSB),
      .IDX_W  (IDX_W)
   ) u_bus (
      .clk   (clk),
      .arst  (arst),
      .cyc   (bus_cyc),
      .stb   (bus_stb),
      .we    (bus_we),
      .adr   (bus_adr),
      .ack   (bus_ack),
      .wr_acc(wr_acc),
      .rd_acc(rd_acc),
      .idx   (idx)
   );

   // writable bank
   logic [DATA_W-1:0] rw_q [RW_WORDS];

   generate
      for (genvar j = 0; j < RW_WORDS; j++) begin : g_rw
         localparam logic [DATA_W-1:0] RV = (j == CTL_OFS) ? CTL_RESET : '0;
         logic hit;
         assign hit = wr_acc && (int'(idx) == int'(RW_BASE + j));
         mcr_rw_word #(
            .W        (DATA_W),
            .RESET_VAL(RV)
         ) u_word (
            .clk (clk),
            .arst(arst),
            .wr  (hit),
            .sel (bus_sel),
            .d   (bus_wdat),
            .q   (rw_q[j])
         );
      end
      for (genvar h = 0; h < HDR_WORDS; h++) begin : g_hdr_out
         assign cfg_header[h*DATA_W +: DATA_W] = rw_q[HDR_OFS + h];
      end
      for (genvar f = 0; f < DIFF_WORDS; f++) begin : g_diff_out
         assign cfg_diff[f*DATA_W +: DATA_W] = rw_q[DIFF_OFS + f];
      end
      for (genvar s = 0; s < START_WORDS; s++) begin : g_start_out
         assign cfg_start[s*DATA_W +: DATA_W] = rw_q[START_OFS + s];
      end
   endgenerate

   assign cfg_run       = rw_q[CTL_OFS][CTL_RUN_BIT];
   assign cfg_test      = rw_q[CTL_OFS][CTL_TEST_BIT];
   assign cfg_halt      = rw_q[CTL_OFS][CTL_HALT_BIT];
   assign cfg_pad_last  = rw_q[CTL_OFS][CTL_PADL_LSB +: 8];
   assign cfg_pad_first = rw_q[CTL_OFS][CTL_PADF_LSB +: 8];

   // read selection
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      status_word    = '0;
      status_word[0] = core_found;
      status_word[1] = core_running;
      status_word[2] = core_testing;
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < int'(SOLN_WORDS); k++) begin
         if (int'(idx) == k) rd_mux = core_soln[k*DATA_W +: DATA_W];
      end
      if (int'(idx) == int'(STAT_IDX)) rd_mux = status_word;
      if (int'(idx) == int'(ID_IDX))   rd_mux = ID_WORD;
      for (int j = 0; j < int'(RW_WORDS); j++) begin
         if (int'(idx) == int'(RW_BASE) + j) rd_mux = rw_q[j];
      end
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst)        bus_rdat <= '0;
      else if (rd_acc) bus_rdat <= rd_mux;
      else             bus_rdat <= '0;
   end

   // interrupt
   logic ctl_rd;
   assign ctl_rd = rd_acc && (int'(idx) == int'(CTL_IDX));

   mcr_irq u_irq (
      .clk  (clk),
      .arst (arst),
      .found(core_found),
      .clr  (ctl_rd),
      .irq  (irq)
   );

   AST_RDAT_IDLE: assert property (@(posedge clk) disable iff (arst)
      !bus_ack |-> (bus_rdat == '0)); // R2
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (arst)
      (bus_ack && $past(int'(idx) >= int'(NUM_WORDS))) |-> (bus_rdat == '0)); // R11
   AST_ID_CONST: assert property (@(posedge clk) disable iff (arst)
      (bus_ack && $past(rd_acc && int'(idx) == int'(ID_IDX))) |-> (bus_rdat == ID_WORD)); // R9
   AST_STATUS_READ: assert property (@(posedge clk) disable iff (arst)
      (bus_ack && $past(rd_acc && int'(idx) == int'(STAT_IDX))) |-> (bus_rdat[DATA_W-1:3] == '0)); // R8

endmodule

// File: tb/miner_cfg_regs_test.sv
module miner_cfg_regs_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         arst;
   logic         bus_cyc, bus_stb, bus_we;
   logic [3:0]   bus_sel;
   logic [31:0]  bus_adr, bus_wdat;
   logic         bus_ack;
   logic [31:0]  bus_rdat;
   logic         core_found, core_running, core_testing;
   logic [63:0]  core_soln;
   logic [255:0] cfg_header, cfg_diff;
   logic [63:0]  cfg_start;
   logic         cfg_run, cfg_test, cfg_halt;
   logic [7:0]   cfg_pad_last, cfg_pad_first;
   logic         irq;

   miner_cfg_regs uut (
      .clk(clk), .arst(arst),
      .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_ack(bus_ack), .bus_rdat(bus_rdat),
      .core_found(core_found), .core_running(core_running), .core_testing(core_testing),
      .core_soln(core_soln),
      .cfg_header(cfg_header), .cfg_diff(cfg_diff), .cfg_start(cfg_start),
      .cfg_run(cfg_run), .cfg_test(cfg_test), .cfg_halt(cfg_halt),
      .cfg_pad_last(cfg_pad_last), .cfg_pad_first(cfg_pad_first), .irq(irq)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // bench-side model of the writable words (bank order: header, threshold, start, control)
   logic [31:0] mdl [19];

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] sel);
      logic [31:0] r;
      r = old;
      for (int b = 0; b < 4; b++) if (sel[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard when acknowledge is seen
   always @(negedge clk) begin
      if (bus_ack && !bus_we && bus_cyc) begin
         if (sb_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R2: unexpected read acknowledge, actual %h expected none", bus_rdat);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, 256'(bus_rdat), 256'(e.exp));
         end
      end
   end

   task automatic xfer(input bit we, input int idx, input logic [31:0] d,
                       input logic [3:0] sel, input logic [31:0] exp, input string tag);
      bit got;
      if (!we) sb_q.push_back('{exp: exp, tag: tag});
      @(posedge clk); #1;
      bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we;
      bus_adr = 32'(idx * 4); bus_wdat = d; bus_sel = sel;
      got = 1'b0;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge clk);
         if (bus_ack) got = 1'b1;
      end
      if (!got) chk({tag, " R2 no ack"}, 256'(0), 256'(1));
      @(posedge clk); #1;
      bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] sel);
      xfer(1'b1, idx, d, sel, 32'h0, "");
      if (idx >= 4 && idx <= 22) mdl[idx-4] = merge(mdl[idx-4], d, sel);
   endtask

   task automatic rd(input int idx, input logic [31:0] exp, input string tag);
      xfer(1'b0, idx, 32'h0, 4'hF, exp, tag);
   endtask

   function automatic logic [255:0] m_hdr();
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = mdl[i];
      return r;
   endfunction

   function automatic logic [255:0] m_diff();
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = mdl[8+i];
      return r;
   endfunction

   task automatic chk_cfg(input string tag);
      chk({tag, " header"}, cfg_header, m_hdr());
      chk({tag, " threshold"}, cfg_diff, m_diff());
      chk({tag, " start"}, 256'(cfg_start), 256'({mdl[17], mdl[16]}));
      chk({tag, " control"}, 256'({cfg_pad_first, cfg_pad_last, cfg_halt, cfg_test, cfg_run}),
          256'({mdl[18][31:24], mdl[18][23:16], mdl[18][2], mdl[18][1], mdl[18][0]}));
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      arst = 1'b1;
      bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0; bus_sel = 4'h0;
      bus_adr = '0; bus_wdat = '0;
      core_found = 1'b0; core_running = 1'b0; core_testing = 1'b0;
      core_soln = '0;
      for (int i = 0; i < 19; i++) mdl[i] = 32'h0;
      mdl[18] = 32'h0680_0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ack in reset", 256'(bus_ack), 256'(0));
      chk("R1 irq in reset", 256'(irq), 256'(0));
      @(posedge clk); #1 arst = 1'b0;
      @(negedge clk);

      // R1: reset values
      chk_cfg("R1");
      chk("R1 irq", 256'(irq), 256'(0));
      rd(22, 32'h0680_0000, "R1 control readback");
      rd(4, 32'h0, "R1 header word");

      // R9: identification word
      rd(3, 32'h5348_4133, "R9 id word");

      // R8: status patterns
      core_running = 1'b1;
      rd(2, 32'h2, "R8 status running");
      core_testing = 1'b1;
      rd(2, 32'h6, "R8 status running+testing");
      core_running = 1'b0;
      rd(2, 32'h4, "R8 status testing");

      // R7: solution words, low word first
      core_soln = 64'h0123_4567_89AB_CDEF;
      rd(0, 32'h89AB_CDEF, "R7 solution low");
      rd(1, 32'h0123_4567, "R7 solution high");
      core_soln = 64'hFEDC_BA98_7654_3210;
      rd(0, 32'h7654_3210, "R7 solution low 2");

      // R3: header words, lowest index carries bits 31:0
      for (int i = 0; i < 8; i++) wr(4 + i, 32'hA500_0000 ^ (32'h1111_1111 * (i + 1)), 4'hF);
      chk("R3 header output", cfg_header, m_hdr());
      rd(4, mdl[0], "R3 header word 4");
      rd(11, mdl[7], "R3 header word 11");

      // R4: threshold and start nonce
      for (int i = 0; i < 8; i++) wr(12 + i, 32'h0F0F_0000 + 32'(i * 3 + 1), 4'hF);
      wr(20, 32'hCAFE_0001, 4'hF);
      wr(21, 32'h0000_BEEF, 4'hF);
      chk("R4 threshold output", cfg_diff, m_diff());
      chk("R4 start output", 256'(cfg_start), 256'(64'h0000_BEEF_CAFE_0001));
      rd(19, mdl[15], "R4 threshold word 19");
      rd(20, 32'hCAFE_0001, "R4 start word 20");

      // R5: control fields
      wr(22, 32'h0180_0005, 4'hF);
      chk("R5 run", 256'(cfg_run), 256'(1));
      chk("R5 test", 256'(cfg_test), 256'(0));
      chk("R5 halt", 256'(cfg_halt), 256'(1));
      chk("R5 pad last", 256'(cfg_pad_last), 256'(8'h80));
      chk("R5 pad first", 256'(cfg_pad_first), 256'(8'h01));
      wr(22, 32'h0611_0002, 4'hF);
      chk_cfg("R5");

      // R6: byte lanes
      wr(4, 32'hFFFF_FFFF, 4'b0101);
      chk("R6 header lanes 0,2", cfg_header, m_hdr());
      rd(4, mdl[0], "R6 header word readback");
      wr(21, 32'h1234_5678, 4'b1000);
      chk("R6 start lane 3", 256'(cfg_start), 256'({mdl[17], mdl[16]}));
      wr(13, 32'hDEAD_DEAD, 4'b0000);
      chk("R6 zero select", cfg_diff, m_diff());
      wr(22, 32'h0000_00FF, 4'b0001);
      chk_cfg("R6 control lane 0");

      // R10: writes to read-only and unmapped words are ignored
      for (int i = 0; i < 4; i++) wr(i, 32'hFFFF_FFFF, 4'hF);
      for (int i = 23; i < 32; i++) wr(i, 32'hFFFF_FFFF, 4'hF);
      chk_cfg("R10");
      rd(3, 32'h5348_4133, "R10 id after write");
      rd(0, 32'h7654_3210, "R10 solution after write");
      for (int i = 0; i < 19; i++) rd(4 + i, mdl[i], "R10 writable readback");

      // R11: unmapped reads
      for (int i = 23; i < 32; i++) rd(i, 32'h0, "R11 unmapped read");

      // R2: no acknowledge without cycle, one-cycle acknowledge
      @(posedge clk); #1;
      bus_stb = 1'b1; bus_cyc = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 stb without cyc", 256'(bus_ack), 256'(0));
      end
      @(posedge clk); #1 bus_stb = 1'b0;
      rd(3, 32'h5348_4133, "R2 read");
      @(negedge clk);
      chk("R2 ack single cycle", 256'(bus_ack), 256'(0));
      chk("R2 rdat idle", 256'(bus_rdat), 256'(0));

      // R12: interrupt life cycle
      rd(22, mdl[18], "R12 pre-clear read");
      chk("R12 irq idle", 256'(irq), 256'(0));
      @(posedge clk); #1 core_found = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 irq set on rise", 256'(irq), 256'(1));
      rd(2, 32'h5, "R8 status found+testing");
      chk("R12 irq kept after status read", 256'(irq), 256'(1));
      wr(22, mdl[18], 4'hF);
      chk("R12 irq kept after control write", 256'(irq), 256'(1));
      rd(22, mdl[18], "R12 clearing read");
      @(negedge clk);
      chk("R12 irq cleared", 256'(irq), 256'(0));
      repeat (3) @(negedge clk);
      chk("R12 level found does not re-arm", 256'(irq), 256'(0));
      @(posedge clk); #1 core_found = 1'b0;
      @(posedge clk); #1 core_found = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 second rise sets", 256'(irq), 256'(1));
      rd(22, mdl[18], "R12 second clear");
      @(negedge clk);
      chk("R12 irq cleared again", 256'(irq), 256'(0));

      repeat (2) @(negedge clk);
      if (sb_q.size() != 0) chk("R2 pending reads", 256'(sb_q.size()), 256'(0));
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule